// File: doc/BRIEF.md
# Four-Bit Lookahead Adder/Subtractor

This block is a purely combinational arithmetic unit. It adds or subtracts two 4-bit operands, called A and B. A single mode line selects the operation. When the mode line is low, the unit forms B + A + carry_in. When the mode line is high, it forms B − A in two's complement. To do this, every bit of A is complemented through an XOR gate against the mode line, and the same mode line is fed into the adder core as its carry, which supplies the +1.

The core does not pass its carry from bit to bit. Each bit position has a generate term (both operand bits high) and a propagate term (either operand bit high). The carry into every position is then written directly as a sum of products of these terms and the initial carry, so no carry waits on the one below it. Each sum bit is the XOR of the two conditioned operand bits and that position's carry.

The 4-bit result together with the carry-out forms a 5-bit sum, with the carry-out as its most significant bit. In subtract mode the carry-out means "no borrow". A separate borrow flag gives the inverse of the carry-out in subtract mode and stays low in add mode. The block has no clock and no reset.

Top module: `addsub_lookahead`

## Requirements
- R1: With sub_mode = 0, {carry_out, result} equals the 5-bit value opb + opa + carry_in for all operand and carry_in values.
- R2: With sub_mode = 1, {carry_out, result} equals the 5-bit value opb + (bitwise NOT opa) + 1, so result equals (opb − opa) modulo 16.
- R3: With sub_mode = 1, carry_out is 1 exactly when opb ≥ opa, taking both operands as unsigned.
- R4: borrow_out equals NOT carry_out when sub_mode = 1, and is 0 when sub_mode = 0.
- R5: With sub_mode = 1, carry_in has no effect: result, carry_out and borrow_out are the same for carry_in = 0 and carry_in = 1.
- R6: The outputs depend only on the present inputs. A new input pattern is reflected at the outputs within the same clock period of the surrounding logic, with no storage between patterns.
- R7: The carry-out equals the majority of the top bit's conditioned operand bits and that bit's carry. At the extremes, 15 + 15 + 1 gives result 15 with carry_out 1, and 0 − 1 gives result 15 with carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | Operand A: the addend, or the subtrahend in subtract mode |
| opb | input | 4 | Operand B: the augend, or the minuend in subtract mode |
| carry_in | input | 1 | External carry, used only in add mode |
| sub_mode | input | 1 | 0 = add, 1 = subtract (B − A) |
| result | output | 4 | Low four bits of the sum or difference |
| carry_out | output | 1 | Fifth sum bit; in subtract mode high means no borrow |
| borrow_out | output | 1 | High when B < A in subtract mode; low in add mode |

## Verification
A wrong generate, propagate or lookahead term shows up at once, in the same input pattern, as a result bit or carry_out that differs from the 5-bit arithmetic sum. The wrong bit is at the position whose carry was corrupted or above it. A fault in operand conditioning or carry selection shows only in one mode, or only for one carry_in value. For that reason the exhaustive sweep covers both modes and both carry_in values for every operand pair. Because nothing is stored, every pattern is judged on its own, in the cycle it is applied.

// File: rtl/addsub_lookahead_pkg.sv
// Shared definitions for the lookahead adder/subtractor.
// Assumes: operands are unsigned bit vectors of ADDSUB_WIDTH bits.
package addsub_lookahead_pkg;

    localparam int ADDSUB_WIDTH = 4;

    // Operation selected by the mode line.
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } arith_mode_e;

endpackage

// File: rtl/addsub_operand_cond.sv
// Operand conditioning: XORs every bit of A with the mode line and picks the
// carry fed to the core (external carry in add mode, constant one in subtract).
// Assumes: purely combinational, no clock.
module addsub_operand_cond #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic         ext_carry,
    input  logic         mode_sub,
    output logic [W-1:0] a_cond,
    output logic         core_carry
);

    // Per-bit XOR against the mode line.
    for (genvar gi = 0; gi < W; gi++) begin : g_xor
        assign a_cond[gi] = a_in[gi] ^ mode_sub;
    end

    // Carry selection; subtract mode supplies the +1 of two's complement.
    always_comb begin
        core_carry = mode_sub ? 1'b1 : ext_carry;
    end

endmodule

// File: rtl/addsub_pg_cells.sv
// Per-bit generate, propagate and half-sum terms.
// Assumes: propagate is the inclusive OR of the operand bits.
module addsub_pg_cells #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] hsum
);

    for (genvar gi = 0; gi < W; gi++) begin : g_cell
        assign gen[gi]  = x[gi] & y[gi];
        assign prop[gi] = x[gi] | y[gi];
        assign hsum[gi] = x[gi] ^ y[gi];
    end

endmodule

// File: rtl/addsub_carry_lookahead.sv
// Lookahead carry network. The carry into position i is a flat sum of
// products of the generate/propagate terms and the initial carry, with no
// carry chained from the position below.
// Assumes: W is small, since the product terms grow quadratically.
module addsub_carry_lookahead #(
    parameter int W = 4
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         c0,
    output logic [W:0]   carry
);

    // Builds every carry from primary terms only.
    always_comb begin
        logic acc;
        logic term;
        for (int i = 0; i <= W; i++) begin
            term = c0;
            for (int k = 0; k < i; k++) begin
                term = term & prop[k];
            end
            acc = term;
            for (int j = 0; j < i; j++) begin
                term = gen[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & prop[k];
                end
                acc = acc | term;
            end
            carry[i] = acc;
        end
    end

endmodule

// File: rtl/addsub_lookahead.sv
// Four-bit add/subtract unit on a lookahead adder core.
// sub_mode = 0: {carry_out,result} = opb + opa + carry_in.
// sub_mode = 1: {carry_out,result} = opb + ~opa + 1, and carry_in is ignored.
// Assumes: purely combinational; the borrow flag is meaningful only in subtract mode.
module addsub_lookahead
    import addsub_lookahead_pkg::*;
#(
    parameter int WIDTH = ADDSUB_WIDTH
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             carry_in,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             borrow_out
);

    localparam int NCARRY = WIDTH + 1;

    arith_mode_e      mode;
    logic [WIDTH-1:0] a_cond;
    logic             c_core;
    logic [WIDTH-1:0] g_bits;
    logic [WIDTH-1:0] p_bits;
    logic [WIDTH-1:0] h_bits;
    logic [NCARRY-1:0] c_bits;

    // Decodes the mode line into the operation type.
    always_comb begin
        mode = sub_mode ? MODE_SUB : MODE_ADD;
    end

    addsub_operand_cond #(.W(WIDTH)) i_cond (
        .a_in       (opa),
        .ext_carry  (carry_in),
        .mode_sub   (sub_mode),
        .a_cond     (a_cond),
        .core_carry (c_core)
    );

    addsub_pg_cells #(.W(WIDTH)) i_pg (
        .x    (opb),
        .y    (a_cond),
        .gen  (g_bits),
        .prop (p_bits),
        .hsum (h_bits)
    );

    addsub_carry_lookahead #(.W(WIDTH)) i_cla (
        .gen   (g_bits),
        .prop  (p_bits),
        .c0    (c_core),
        .carry (c_bits)
    );

    // Sum bits: half-sum XOR the carry into each position.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_sum
        assign result[gi] = h_bits[gi] ^ c_bits[gi];
    end

    // Carry-out and the borrow flag for subtract mode.
    always_comb begin
        carry_out  = c_bits[WIDTH];
        borrow_out = (mode == MODE_SUB) ? ~c_bits[WIDTH] : 1'b0;
    end

endmodule

// File: rtl/addsub_lookahead_chk.sv
// Assertion checker for addsub_lookahead, attached by bind.
// Assumes: inputs may be unknown before the environment drives them; checks wait for known values.
module addsub_lookahead_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             carry_in,
    input logic             sub_mode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             borrow_out
);

    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;
    logic           known;

    // Arithmetic reference values and an input-known guard.
    always_comb begin
        add_ref = {1'b0, opb} + {1'b0, opa} + {{WIDTH{1'b0}}, carry_in};
        sub_ref = {1'b0, opb} + {1'b0, ~opa} + {{WIDTH{1'b0}}, 1'b1};
        known   = !$isunknown({opa, opb, carry_in, sub_mode});
    end

    // Output checks against arithmetic, one per requirement.
    always_comb begin
        if (known && !sub_mode) begin
            a_r1_add_sum: assert ({carry_out, result} == add_ref)
                else $error("R1 add mismatch");
        end
        if (known && sub_mode) begin
            a_r2_sub_diff: assert ({carry_out, result} == sub_ref)
                else $error("R2 subtract mismatch");
            a_r3_no_borrow_when_ge: assert (carry_out == (opb >= opa))
                else $error("R3 carry-out vs compare mismatch");
        end
        if (known) begin
            a_r4_borrow_inverse: assert (borrow_out == (sub_mode & ~carry_out))
                else $error("R4 borrow flag mismatch");
        end
    end

endmodule

bind addsub_lookahead addsub_lookahead_chk #(.WIDTH(WIDTH)) i_addsub_lookahead_chk (
    .opa        (opa),
    .opb        (opb),
    .carry_in   (carry_in),
    .sub_mode   (sub_mode),
    .result     (result),
    .carry_out  (carry_out),
    .borrow_out (borrow_out)
);

// File: tb/test_addsub_lookahead.sv
// Directed bench for addsub_lookahead: one task per scenario.
module test_addsub_lookahead;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic       carry_in = 1'b0;
    logic       sub_mode = 1'b0;
    logic [3:0] result;
    logic       carry_out;
    logic       borrow_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    addsub_lookahead i_addsub_lookahead (
        .opa        (opa),
        .opb        (opb),
        .carry_in   (carry_in),
        .sub_mode   (sub_mode),
        .result     (result),
        .carry_out  (carry_out),
        .borrow_out (borrow_out)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d cin=%0d sub=%0d)",
                     tag, actual, expected, opa, opb, carry_in, sub_mode);
        end
    endtask

    // Drives a pattern after a rising edge; outputs are sampled at the falling edge.
    task automatic apply(input int a, input int b, input bit ci, input bit sb);
        @(posedge clk);
        opa = a[3:0]; opb = b[3:0]; carry_in = ci; sub_mode = sb;
        @(negedge clk);
    endtask

    task automatic test_idle();
        apply(0, 0, 1'b0, 1'b0);
        chk("R1 idle result", int'(result), 0);
        chk("R1 idle carry", int'(carry_out), 0);
        chk("R4 idle borrow", int'(borrow_out), 0);
    endtask

    task automatic test_add_sweep();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int ci = 0; ci < 2; ci++) begin
                    apply(a, b, ci[0], 1'b0);
                    chk("R1 add sum", int'({carry_out, result}), b + a + ci);
                    chk("R4 add borrow low", int'(borrow_out), 0);
                end
    endtask

    task automatic test_sub_sweep();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                apply(a, b, 1'b0, 1'b1);
                chk("R2 sub value", int'({carry_out, result}), (b + (15 - a) + 1) % 32);
                chk("R3 no-borrow carry", int'(carry_out), (b >= a) ? 1 : 0);
                chk("R4 borrow inverse", int'(borrow_out), (b < a) ? 1 : 0);
            end
    endtask

    task automatic test_cin_ignored();
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b += 5) begin
                apply(a, b, 1'b1, 1'b1);
                chk("R5 cin ignored value", int'({carry_out, result}), (b + 16 - a) % 32);
                chk("R5 cin ignored borrow", int'(borrow_out), (b < a) ? 1 : 0);
            end
    endtask

    task automatic test_extremes();
        apply(15, 15, 1'b1, 1'b0);
        chk("R7 max add result", int'(result), 15);
        chk("R7 max add carry", int'(carry_out), 1);
        apply(1, 0, 1'b0, 1'b1);
        chk("R7 zero minus one result", int'(result), 15);
        chk("R7 zero minus one carry", int'(carry_out), 0);
        apply(7, 7, 1'b1, 1'b1);
        chk("R3 equal operands carry", int'(carry_out), 1);
        chk("R2 equal operands result", int'(result), 0);
    endtask

    task automatic test_no_memory();
        apply(15, 15, 1'b1, 1'b0);
        apply(0, 1, 1'b0, 1'b0);
        chk("R6 same-period update", int'({carry_out, result}), 1);
        apply(3, 2, 1'b0, 1'b1);
        chk("R6 mode switch update", int'({carry_out, result}), 15);
        apply(2, 3, 1'b0, 1'b0);
        chk("R6 back to add", int'({carry_out, result}), 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_idle();
        test_add_sweep();
        test_sub_sweep();
        test_cin_ignored();
        test_extremes();
        test_no_memory();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule